// File: doc/BRIEF.md
# Sync activity detector and source selector

This block watches the raw horizontal sync, vertical sync and sync-on-green inputs. It raises a separate activity flag for each of the three inputs. An input counts as active only while it keeps toggling. A line that sits at a constant level, high or low, reads as inactive once a programmable number of reference-clock cycles has passed with no edge.

From those flags the block picks the horizontal source that feeds the downstream PLL: either the dedicated horizontal pin or sync-on-green. It also picks the vertical source: either the dedicated vertical pin or the output of an external sync separator. The separator works on sync-on-green, so the sync-on-green flag stands in as the separator's activity.

When both candidates of a pair are live, a priority bit chooses between them. An override bit forces the choice to the priority bit whatever the flags show. The selected signals are passed out after synchronisation so that downstream logic can use them directly.

Top module: `sync_src_select`

## Requirements
- R1: Each of `hs_in`, `vs_in` and `sog_in` passes through two synchronising flops. An edge on an input sets its flag (`hs_act`, `vs_act`, `sog_act`) three rising clock edges after the input changes.
- R2: A flag clears after `win_len` consecutive clock cycles with no edge on its input. A level change seen at rising edge P1 keeps the flag at 1 through edge P(2+win_len), and the flag is 0 after edge P(3+win_len) if no further change occurs. An input held constant reads 0 (`win_len` must be at least 1).
- R3: `h_pick` is 0 for the horizontal pin and 1 for sync-on-green. With the override off, if only one of `hs_act`/`sog_act` is 1, that source is picked. If neither is 1, 0 is picked.
- R4: With the override off and both `hs_act` and `sog_act` at 1, `h_pick` takes the value of `h_prio`.
- R5: With `h_force` at 1, `h_pick` takes the value of `h_prio` whatever the flags show.
- R6: `v_pick` is 0 for the vertical pin and 1 for the separator output. With the override off, if only one of `vs_act`/`sog_act` is 1, that source is picked (`vs_act` gives 0, `sog_act` gives 1). If neither is 1, 0 is picked.
- R7: `v_pick` takes the value of `v_prio` when `v_force` is 1, or when the override is off and both `vs_act` and `sog_act` are 1.
- R8: Both picks are registered. They follow a change of flags or control bits one clock later and hold their value otherwise.
- R9: `hs_sel` carries the twice-synchronised source named by `h_pick`. `vs_sel` carries the twice-synchronised source named by `v_pick`.
- R10: While `rst_n` is low, all flags and both picks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| hs_in | input | 1 | Horizontal sync pin |
| vs_in | input | 1 | Vertical sync pin |
| sog_in | input | 1 | Sync-on-green input |
| sep_vs_in | input | 1 | Vertical sync from the sync separator |
| win_len | input | WIN_W | Idle window length in clock cycles (at least 1) |
| h_prio | input | 1 | Horizontal priority / forced value |
| h_force | input | 1 | Horizontal override enable |
| v_prio | input | 1 | Vertical priority / forced value |
| v_force | input | 1 | Vertical override enable |
| hs_act | output | 1 | Horizontal pin activity flag |
| vs_act | output | 1 | Vertical pin activity flag |
| sog_act | output | 1 | Sync-on-green activity flag |
| h_pick | output | 1 | Horizontal source select |
| v_pick | output | 1 | Vertical source select |
| hs_sel | output | 1 | Selected horizontal sync |
| vs_sel | output | 1 | Selected vertical sync |

## Verification
The bench keeps the default `WIN_W` of 8 and drives `win_len` at run time. A value of 5 makes the exact cycle in which a flag drops observable in a short directed test. A value of 20 lets random patterns of live and idle inputs settle in under a hundred cycles, so every combination of flags, priority and override can be reached many times. During the check window, idle inputs and the final levels of live inputs are held at distinct values, so the routed outputs show which source was picked.

// File: rtl/sync_src_select.sv
module sync_src_select #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             sog_in,
  input  logic             sep_vs_in,
  input  logic [WIN_W-1:0] win_len,
  input  logic             h_prio,
  input  logic             h_force,
  input  logic             v_prio,
  input  logic             v_force,
  output logic             hs_act,
  output logic             vs_act,
  output logic             sog_act,
  output logic             h_pick,
  output logic             v_pick,
  output logic             hs_sel,
  output logic             vs_sel
);
  localparam int NCH = 3;

  logic [NCH-1:0] raw, s1, s2, s3, act;
  logic           sep1, sep2;

  assign raw = {sog_in, vs_in, hs_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; sep1 <= 1'b0; sep2 <= 1'b0;
    end else begin
      s1 <= raw; s2 <= s1; s3 <= s2; sep1 <= sep_vs_in; sep2 <= sep1;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_det
    logic [WIN_W-1:0] idle;
    wire              edge_seen = s2[i] ^ s3[i];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        idle   <= '0;
        act[i] <= 1'b0;
      end else if (edge_seen) begin
        idle   <= '0;
        act[i] <= 1'b1;
      end else begin
        if (idle != win_len) idle <= idle + 1'b1;
        if (idle == win_len - 1'b1) act[i] <= 1'b0;
      end
  end

  assign hs_act  = act[0];
  assign vs_act  = act[1];
  assign sog_act = act[2];

  function automatic logic pick(input logic a, input logic b,
                                input logic prio, input logic force_on);
    if (force_on || (a && b)) return prio;
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      h_pick <= 1'b0;
      v_pick <= 1'b0;
    end else begin
      h_pick <= pick(act[0], act[2], h_prio, h_force);
      v_pick <= pick(act[1], act[2], v_prio, v_force);
    end

  assign hs_sel = h_pick ? s2[2] : s2[0];
  assign vs_sel = v_pick ? sep2 : s2[1];
endmodule

module sync_src_select_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_act,
  input logic vs_act,
  input logic sog_act,
  input logic h_prio,
  input logic h_force,
  input logic v_prio,
  input logic v_force,
  input logic h_pick,
  input logic v_pick
);
  assert_hpick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_force && (hs_act != sog_act)) |=> (h_pick == $past(sog_act)));
  assert_hpick_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_force && !hs_act && !sog_act) |=> !h_pick);
  assert_hpick_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_act && sog_act) |=> (h_pick == $past(h_prio)));
  assert_hpick_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_force |=> (h_pick == $past(h_prio)));
  assert_vpick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_force && (vs_act != sog_act)) |=> (v_pick == $past(sog_act)));
  assert_vpick_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_force || (vs_act && sog_act)) |=> (v_pick == $past(v_prio)));
  assert_pick_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(hs_act) && $stable(vs_act) && $stable(sog_act) && $stable(h_prio)
     && $stable(h_force) && $stable(v_prio) && $stable(v_force))
    |=> ($stable(h_pick) && $stable(v_pick)));
  always_comb if (!rst_n) assert_reset_R10: assert (!h_pick && !v_pick);
endmodule

bind sync_src_select sync_src_select_chk u_chk (.*);

// File: tb/test_sync_src_select.sv
module test_sync_src_select;
  logic clk = 0, rst_n = 0;
  logic hs_in = 0, vs_in = 0, sog_in = 0, sep_vs_in = 0;
  logic [7:0] win_len = 8'd5;
  logic h_prio = 0, h_force = 0, v_prio = 0, v_force = 0;
  logic hs_act, vs_act, sog_act, h_pick, v_pick, hs_sel, vs_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_src_select #(.WIN_W(8)) i_sync_src_select (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic exp_pick(input logic a, input logic b,
                                    input logic prio, input logic frc);
    if (frc) return prio;
    if (a && b) return prio;
    if (a) return 1'b0;
    if (b) return 1'b1;
    return 1'b0;
  endfunction

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    h_prio = 1; h_force = 1; v_prio = 1; v_force = 1;
    ticks(3);
    chk("R10 hs_act", hs_act, 0); chk("R10 vs_act", vs_act, 0);
    chk("R10 sog_act", sog_act, 0);
    chk("R10 h_pick", h_pick, 0); chk("R10 v_pick", v_pick, 0);
    h_prio = 0; h_force = 0; v_prio = 0; v_force = 0;
    rst_n = 1;
    ticks(2);

    // R2: constant-high input stays inactive
    hs_in = 1; ticks(1); hs_in = 1; ticks(30);
    // the single 0->1 step is an edge; after the window it must read idle
    chk("R2 constant high", hs_act, 0);

    // R1 / R2 exact timing with win_len = 5
    hs_in = 0;
    ticks(2); chk("R1 not before P3", hs_act, 0);
    ticks(1); chk("R1 set at P3", hs_act, 1);
    ticks(win_len - 1); chk("R2 held at P2+win", hs_act, 1);
    ticks(1); chk("R2 cleared at P3+win", hs_act, 0);
    ticks(20); chk("R2 constant low", hs_act, 0);

    // R8: force change is reflected exactly one clock later
    h_force = 1; h_prio = 1;
    ticks(1); chk("R8 pick follows one clock later", h_pick, 1);
    h_force = 0; h_prio = 0;
    ticks(1); chk("R3 neither active", h_pick, 0);

    // Random mix: live inputs toggle, idle inputs hold their final level
    win_len = 8'd20;
    for (int it = 0; it < 120; it++) begin
      logic [3:0] live;
      logic eh, ev;
      live = 4'($urandom);
      h_prio = 1'($urandom); h_force = 1'($urandom);
      v_prio = 1'($urandom); v_force = 1'($urandom);
      if (!live[0]) hs_in = 1; if (!live[1]) vs_in = 0;
      if (!live[2]) sog_in = 0; if (!live[3]) sep_vs_in = 1;
      for (int c = 0; c < 60; c++) begin
        if (c % 3 == 0) begin
          if (live[0]) hs_in = ~hs_in;
          if (live[1]) vs_in = ~vs_in;
          if (live[2]) sog_in = ~sog_in;
          if (live[3]) sep_vs_in = ~sep_vs_in;
        end
        ticks(1);
      end
      hs_in = 1; vs_in = 0; sog_in = 0; sep_vs_in = 1;
      ticks(4);
      eh = exp_pick(live[0], live[2], h_prio, h_force);
      ev = exp_pick(live[1], live[2], v_prio, v_force);
      chk("R1 hs_act", hs_act, live[0]);
      chk("R1 vs_act", vs_act, live[1]);
      chk("R1 sog_act", sog_act, live[2]);
      if (h_force) chk("R5 h_pick", h_pick, eh);
      else if (live[0] && live[2]) chk("R4 h_pick", h_pick, eh);
      else chk("R3 h_pick", h_pick, eh);
      if (v_force || (live[1] && live[2])) chk("R7 v_pick", v_pick, ev);
      else chk("R6 v_pick", v_pick, ev);
      chk("R9 hs_sel", hs_sel, eh ? 1'b0 : 1'b1);
      chk("R9 vs_sel", vs_sel, ev ? 1'b1 : 1'b0);
      ticks(1);
      chk("R8 h_pick holds", h_pick, eh);
      chk("R8 v_pick holds", v_pick, ev);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule